// File: doc/BRIEF.md
# Alternate-Bank Byte-Stream Pointer Unit

This block holds a 16-bit stream pointer that addresses a second memory bank, separate from the main memory, and moves bytes through it the way a bytecode interpreter walks its code. An external decoder hands it one micro-operation at a time, together with the current Y and A register values. The block drives a simple synchronous memory port towards the second bank. It returns the updated A, Y and pointer values.

Four micro-operations exist. Two stream bytes and advance the pointer by one: one reads into A and one writes from A. One swaps the pointer with the 16-bit pair built from Y and A. One moves the pointer by a signed 8-bit step. The block has no status-flag path, so none of these operations can disturb processor flags. Pointer arithmetic wraps around the 64 KiB space silently.

Top module: `altbank_ptr_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `ptr_out` = 0x0000, `a_out` = `y_out` = 0, and `done`, `mem_en`, `mem_we` and `alt_sel` all low.
- R2: Op code 0 (read-advance). Start is sampled at edge E0. After E0, the block drives `mem_en`=1, `mem_we`=0 and `mem_addr` = the pointer. The RAM returns data after E1. At E2, `a_out` takes `mem_rdata`, the pointer grows by one, and `done` is high in the following cycle.
- R3: Op code 1 (write-advance). After the start edge E0, the block drives `mem_en`=1, `mem_we`=1, `mem_addr` = the pointer and `mem_wdata` = `a_in`. At E1 the pointer grows by one and `done` goes high. `a_out` and `y_out` equal the sampled `a_in` and `y_in`.
- R4: Op code 2 (swap). At the start edge the pointer becomes {`a_in`,`y_in`}, with Y as bits 7:0 and A as bits 15:8. `a_out` takes the old pointer bits 15:8 and `y_out` takes the old bits 7:0. `done` is high in the next cycle.
- R5: Op code 3 (offset). At the start edge the pointer takes pointer + `imm` sign-extended from bit 7. `a_out` and `y_out` equal the sampled inputs. `done` is high in the next cycle.
- R6: All pointer arithmetic is modulo 65536. For example, 0xFFFF advances to 0x0000, and 0x0000 plus 0x80 gives 0xFF80.
- R7: `alt_sel` is high exactly when `mem_en` is high. Swap and offset operations never raise `mem_en`. `mem_we` is never high without `mem_en`.
- R8: Each accepted operation yields exactly one `done` cycle. `done` is never high while the port is enabled, and the pointer changes only in a `done` cycle.
- R9: A `start` sampled while a read or write operation is still in progress is ignored. It causes no port access, no pointer change and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation start pulse |
| op | input | 2 | Operation code: 0 read, 1 write, 2 swap, 3 offset |
| imm | input | 8 | Signed step for the offset operation |
| a_in | input | 8 | Current A value |
| y_in | input | 8 | Current Y value |
| mem_rdata | input | 8 | Read data from the second bank (one-cycle synchronous RAM) |
| mem_en | output | 1 | Second-bank access enable |
| alt_sel | output | 1 | Bank select: the access targets the second bank |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| a_out | output | 8 | Updated A value |
| y_out | output | 8 | Updated Y value |
| ptr_out | output | 16 | Current pointer |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a new `start` landing while a read is between its address cycle and its capture cycle. The hazard is worst when that start is a swap or an offset that would change the pointer at once. A directed case holds `start` high across two edges, so the second request falls inside a read. A long random phase then asserts `start` on about half of all cycles with random codes. This puts requests on every internal phase, including the edge where `done` rises. The pointer is forced near 0xFFFF so that advances and negative offsets cross the wrap boundary.

// File: rtl/altptr_pkg.sv
package altptr_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SWAP  = 2'd2,
    OP_STEP  = 2'd3
  } ptr_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WCOMMIT = 2'd1,
    ST_RWAIT  = 2'd2,
    ST_RCAP   = 2'd3
  } ptr_state_e;

endpackage

// File: rtl/altptr_arith.sv
module altptr_arith #(
  parameter int PTR_W = 16,
  parameter int IMM_W = 8
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic [IMM_W-1:0] step,
  output logic [PTR_W-1:0] ptr_inc,
  output logic [PTR_W-1:0] ptr_step
);
  localparam int EXT_W = PTR_W - IMM_W;

  logic [PTR_W-1:0] step_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign step_ext = {{EXT_W{step[IMM_W-1]}}, step};
    end else begin : g_noext
      assign step_ext = step[PTR_W-1:0];
    end
  endgenerate

  // Both sums drop the carry out, giving modulo wrap.
  assign ptr_inc  = ptr + {{(PTR_W-1){1'b0}}, 1'b1};
  assign ptr_step = ptr + step_ext;
endmodule

// File: rtl/altptr_ctrl.sv
module altptr_ctrl
  import altptr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] op,
  output logic       take,
  output logic       go_read,
  output logic       go_write,
  output logic       go_swap,
  output logic       go_step,
  output logic       commit_inc,
  output logic       capture
);
  ptr_state_e state, state_nx;
  ptr_op_e    op_e;

  assign op_e = ptr_op_e'(op);
  assign take = start && (state == ST_IDLE);

  always_comb begin
    go_read    = take && (op_e == OP_READ);
    go_write   = take && (op_e == OP_WRITE);
    go_swap    = take && (op_e == OP_SWAP);
    go_step    = take && (op_e == OP_STEP);
    capture    = (state == ST_RCAP);
    commit_inc = (state == ST_RCAP) || (state == ST_WCOMMIT);
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: begin
        if (go_read)       state_nx = ST_RWAIT;
        else if (go_write) state_nx = ST_WCOMMIT;
      end
      ST_RWAIT:   state_nx = ST_RCAP;
      ST_RCAP:    state_nx = ST_IDLE;
      ST_WCOMMIT: state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end
endmodule

// File: rtl/altptr_port.sv
module altptr_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_rd,
  input  logic              issue_wr,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] wdata_d,
  output logic              en_q,
  output logic              sel_q,
  output logic              we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  logic issue;
  assign issue = issue_rd || issue_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      sel_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      en_q  <= issue;
      sel_q <= issue;
      we_q  <= issue_wr;
      if (issue) addr_q <= addr_d;
      if (issue_wr) wdata_q <= wdata_d;
    end
  end
endmodule

// File: rtl/altbank_ptr_unit.sv
module altbank_ptr_unit #(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          op,
  input  logic [IMM_W-1:0]    imm,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   y_in,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                mem_en,
  output logic                alt_sel,
  output logic                mem_we,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W-1:0]   a_out,
  output logic [DATA_W-1:0]   y_out,
  output logic [2*DATA_W-1:0] ptr_out,
  output logic                done
);
  localparam int PTR_W = 2 * DATA_W;

  logic             take, go_read, go_write, go_swap, go_step;
  logic             commit_inc, capture;
  logic [PTR_W-1:0] ptr_q, ptr_inc, ptr_step;
  logic [DATA_W-1:0] a_q, y_q;
  logic             done_q;

  altptr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .take(take), .go_read(go_read), .go_write(go_write),
    .go_swap(go_swap), .go_step(go_step),
    .commit_inc(commit_inc), .capture(capture)
  );

  altptr_arith #(.PTR_W(PTR_W), .IMM_W(IMM_W)) u_arith (
    .ptr(ptr_q), .step(imm), .ptr_inc(ptr_inc), .ptr_step(ptr_step)
  );

  altptr_port #(.ADDR_W(PTR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .issue_rd(go_read), .issue_wr(go_write),
    .addr_d(ptr_q), .wdata_d(a_in),
    .en_q(mem_en), .sel_q(alt_sel), .we_q(mem_we),
    .addr_q(mem_addr), .wdata_q(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (go_swap) begin
      ptr_q <= {a_in, y_in};
    end else if (go_step) begin
      ptr_q <= ptr_step;
    end else if (commit_inc) begin
      ptr_q <= ptr_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      y_q <= '0;
    end else if (go_swap) begin
      a_q <= ptr_q[PTR_W-1:DATA_W];
      y_q <= ptr_q[DATA_W-1:0];
    end else if (take) begin
      a_q <= a_in;
      y_q <= y_in;
    end else if (capture) begin
      a_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= go_swap || go_step || commit_inc;
  end

  assign ptr_out = ptr_q;
  assign a_out   = a_q;
  assign y_out   = y_q;
  assign done    = done_q;
endmodule

// File: rtl/altptr_checker.sv
module altptr_checker #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                mem_en,
  input logic                alt_sel,
  input logic                mem_we,
  input logic [2*DATA_W-1:0] mem_addr,
  input logic [2*DATA_W-1:0] ptr_out,
  input logic                done
);
  localparam int PTR_W = 2 * DATA_W;

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!done && !mem_en && !mem_we && ptr_out == '0));

  a_r7_sel_tracks_en: assert property (@(posedge clk) disable iff (rst)
    alt_sel == mem_en);

  a_r7_we_needs_en: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  a_r3_write_commit: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (done && ptr_out == PTR_W'($past(mem_addr) + 1'b1)));

  a_r2_read_capture: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |=> (!done ##1 (done && ptr_out == PTR_W'($past(mem_addr, 2) + 1'b1))));

  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !mem_en);

  a_r8_done_port_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_en);

  a_r8_ptr_moves_on_done: assert property (@(posedge clk) disable iff (rst)
    (ptr_out != $past(ptr_out)) |-> done);
endmodule

bind altbank_ptr_unit altptr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mem_en(mem_en), .alt_sel(alt_sel), .mem_we(mem_we),
  .mem_addr(mem_addr), .ptr_out(ptr_out), .done(done)
);

// File: tb/sim_altbank_ptr_unit.sv
`timescale 1ns/1ps
module sim_altbank_ptr_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [7:0] imm = 8'd0, a_in = 8'd0, y_in = 8'd0, mem_rdata;
  logic mem_en, alt_sel, mem_we, done;
  logic [15:0] mem_addr, ptr_out;
  logic [7:0] mem_wdata, a_out, y_out;

  always #4 clk = ~clk;

  altbank_ptr_unit u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .imm(imm),
    .a_in(a_in), .y_in(y_in), .mem_rdata(mem_rdata),
    .mem_en(mem_en), .alt_sel(alt_sel), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .a_out(a_out), .y_out(y_out), .ptr_out(ptr_out), .done(done)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  function automatic logic [7:0] seed_byte(input logic [15:0] ad);
    return ad[7:0] ^ ad[15:8] ^ 8'h5A;
  endfunction

  // second-bank RAM: one-cycle synchronous read
  logic [7:0] ram [int];
  logic [7:0] rd_q = 8'h00;
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[int'(mem_addr)] = mem_wdata;
      else rd_q <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : seed_byte(mem_addr);
    end
  end

  // behavioural reference model
  logic [7:0]  shadow [int];
  int          m_left = 0;
  int          m_kind = 0;
  logic [15:0] m_ptr = 0, m_addr = 0;
  logic [7:0]  m_a = 0, m_y = 0, m_wd = 0;
  logic        m_done = 0, m_en = 0, m_we = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_left = 0; m_ptr = 0; m_a = 0; m_y = 0;
      m_done = 0; m_en = 0; m_we = 0; m_addr = 0; m_wd = 0;
    end else begin
      m_done = 0; m_en = 0; m_we = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          m_done = 1;
          if (m_kind == 0)
            m_a = shadow.exists(int'(m_addr)) ? shadow[int'(m_addr)] : seed_byte(m_addr);
          else
            shadow[int'(m_addr)] = m_wd;
          m_ptr = m_ptr + 16'd1;
        end
      end else if (start) begin
        m_a = a_in; m_y = y_in;
        case (op)
          2'd0: begin m_en = 1; m_addr = m_ptr; m_left = 2; m_kind = 0; end
          2'd1: begin m_en = 1; m_we = 1; m_addr = m_ptr; m_wd = a_in; m_left = 1; m_kind = 1; end
          2'd2: begin m_a = m_ptr[15:8]; m_y = m_ptr[7:0]; m_ptr = {a_in, y_in}; m_done = 1; end
          default: begin m_ptr = m_ptr + {{8{imm[7]}}, imm}; m_done = 1; end
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R8 done", {15'd0, done}, {15'd0, m_done});
      chk("R6 ptr_out", ptr_out, m_ptr);
      chk("R7 mem_en", {15'd0, mem_en}, {15'd0, m_en});
      chk("R7 alt_sel", {15'd0, alt_sel}, {15'd0, m_en});
      chk("R3 mem_we", {15'd0, mem_we}, {15'd0, m_we});
      chk("R2 a_out", {8'd0, a_out}, {8'd0, m_a});
      chk("R4 y_out", {8'd0, y_out}, {8'd0, m_y});
      if (m_en) chk("R2 mem_addr", mem_addr, m_addr);
      if (m_we) chk("R3 mem_wdata", {8'd0, mem_wdata}, {8'd0, m_wd});
    end
  end

  task automatic issue(input logic [1:0] o, input logic [7:0] i, input logic [7:0] a, input logic [7:0] y);
    @(negedge clk);
    start = 1'b1; op = o; imm = i; a_in = a; y_in = y;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ptr after reset", ptr_out, 16'h0000);
    chk("R1 done after reset", {15'd0, done}, 16'd0);
    chk("R1 mem_en after reset", {15'd0, mem_en}, 16'd0);

    issue(2'd2, 8'h00, 8'hFF, 8'hFE);
    chk("R4 swap ptr", ptr_out, 16'hFFFE);
    chk("R4 swap old ptr to A/Y", {a_out, y_out}, 16'h0000);

    issue(2'd1, 8'h00, 8'h11, 8'h00);
    issue(2'd1, 8'h00, 8'h22, 8'h00);
    chk("R6 write wraps ptr", ptr_out, 16'h0000);

    issue(2'd2, 8'h00, 8'hFF, 8'hFE);
    chk("R4 swap returns old ptr", {a_out, y_out}, 16'h0000);
    issue(2'd0, 8'h00, 8'h00, 8'h00);
    chk("R2 read first byte", {8'd0, a_out}, 16'h0011);
    issue(2'd0, 8'h00, 8'h00, 8'h00);
    chk("R2 read second byte", {8'd0, a_out}, 16'h0022);
    chk("R6 read wraps ptr", ptr_out, 16'h0000);

    issue(2'd3, 8'h80, 8'h33, 8'h44);
    chk("R5 step -128 from 0", ptr_out, 16'hFF80);
    chk("R5 A/Y kept", {a_out, y_out}, 16'h3344);
    issue(2'd3, 8'h7F, 8'h00, 8'h00);
    chk("R5 step +127", ptr_out, 16'hFFFF);
    issue(2'd3, 8'h01, 8'h00, 8'h00);
    chk("R6 step wraps", ptr_out, 16'h0000);

    // R9: start held across an in-progress read, second request is a swap
    @(negedge clk);
    start = 1'b1; op = 2'd0;
    @(negedge clk);
    op = 2'd2; a_in = 8'hAB; y_in = 8'hCD;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 swap during read ignored", ptr_out, 16'h0001);

    // random phase: starts on any cycle, including busy ones
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      start = ($urandom_range(0, 1) == 1);
      op = 2'($urandom_range(0, 3));
      imm = 8'($urandom_range(0, 255));
      a_in = 8'($urandom_range(0, 255));
      y_in = ($urandom_range(0, 7) == 0) ? 8'hFF : 8'($urandom_range(0, 255));
      if (op == 2'd2 && $urandom_range(0, 3) == 0) a_in = 8'hFF;
    end
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule